// File: doc/BRIEF.md
# Binary Field Add, Square and Shift Unit

This unit is the single-cycle arithmetic stage of a polynomial-basis datapath over GF(2^m). Operands are up to 256 bits wide. Each accepted request picks one of three operations. Addition is a bitwise XOR, which also serves as subtraction. Squaring spreads the operand so that bit i lands on bit 2i and leaves a zero between each pair. Shift left moves the operand up by one position.

The raw result can be up to twice the width of an operand. It is then either passed through unreduced or reduced by one of three sparse irreducible polynomials of fixed degree: t^163+t^7+t^6+t^3+1, t^193+t^15+1 and t^233+t^74+1. The field-select input chooses which. Reduction folds the part above degree m−1 back onto the low terms, because t^m is congruent to M − t^m. The number of folding passes is derived from the worst-case raw degree, so operands that are not in canonical form also come out fully reduced.

Requests enter on a valid/ready handshake, and results leave on a second valid/ready handshake through a single output register. A request is taken on any edge where `in_valid` and `in_ready` are both high. `in_ready` is high when the output register is empty or is being drained in the same cycle. While `out_valid` is high and `out_ready` is low, the result is held unchanged.

Top module: `gf2_sqr_alu`

## Requirements
- R1: With op code 2'b00 and field select 2'b11, the result is `in_a XOR in_b`.
- R2: With op code 2'b01 and field select 2'b11, result bit 2i equals `in_a[i]` for i < 128.
- R3: With op code 2'b10 and field select 2'b11, the result is `in_a` shifted up by one position, with bit 255 dropped and bit 0 zero.
- R4: Field select 2'b00 reduces the raw result modulo t^163+t^7+t^6+t^3+1 for every operation.
- R5: Field select 2'b01 reduces the raw result modulo t^193+t^15+1.
- R6: Field select 2'b10 reduces the raw result modulo t^233+t^74+1.
- R7: After a reduced operation, every result bit at or above the selected degree m is zero.
- R8: A request accepted on a clock edge produces `out_valid` high, with its result, right after that edge. This holds for every field degree.
- R9: `in_ready` equals `!out_valid || out_ready`. While `out_valid` is high and `out_ready` is low, `out_valid` stays high and the result does not change.
- R10: After reset, `out_valid` is low and `in_ready` is high.
- R11: An unreduced square has all odd result bits at zero.
- R12: Op code 2'b11 yields an all-zero raw result, so the output is zero for every field select.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Request can be taken this cycle |
| in_op | input | 2 | 00 add, 01 square, 10 shift left, 11 zero |
| in_fsel | input | 2 | 00 degree 163, 01 degree 193, 10 degree 233, 11 unreduced |
| in_a | input | 256 | First operand |
| in_b | input | 256 | Second operand (add only) |
| out_valid | output | 1 | Result register holds a result |
| out_ready | input | 1 | Consumer takes the result this cycle |
| out_result | output | 256 | Registered result |

## Verification
Several properties are checked on every cycle. The degree bound holds on every reduced result. Odd bits are zero on every unreduced square. A held result stays stable under back-pressure. Every accepted request leads to a valid output on the next edge. Each folding stage also checks that its last pass leaves nothing above degree m. The remaining behaviour can only be shown by the bench's scenarios. Whether the reduced value is the correct residue for each polynomial is compared against a bit-serial long-division model. So are the exact bit patterns of XOR, interleave and shift, including the dropped top bit. The same applies to the zero op code and to the acceptance pattern under random stalls.

// File: rtl/gf2_alu_pkg.sv
package gf2_alu_pkg;
  typedef enum logic [1:0] {
    OP_XOR = 2'b00,
    OP_SQR = 2'b01,
    OP_SHL = 2'b10,
    OP_NUL = 2'b11
  } op_e;

  localparam logic [1:0] FS_163 = 2'b00;
  localparam logic [1:0] FS_193 = 2'b01;
  localparam logic [1:0] FS_233 = 2'b10;
  localparam logic [1:0] FS_RAW = 2'b11;

  // Folding passes needed to bring a raw_w-bit value below degree deg,
  // each pass lowering the top degree by (deg - top_tap).
  function automatic int fold_count(int raw_w, int deg, int top_tap);
    int d;
    int n;
    d = raw_w - 1;
    n = 0;
    while (d >= deg) begin
      d = d - deg + top_tap;
      n++;
    end
    return n;
  endfunction
endpackage

// File: rtl/gf2_interleave.sv
module gf2_interleave #(
  parameter int W = 256
) (
  input  logic [W-1:0]   a,
  output logic [2*W-1:0] sq
);
  // Cross terms cancel in GF(2): bit i goes to bit 2i, odd bits stay zero.
  for (genvar i = 0; i < W; i++) begin : g_spread
    assign sq[2*i]   = a[i];
    assign sq[2*i+1] = 1'b0;
  end
endmodule

// File: rtl/gf2_fold.sv
module gf2_fold #(
  parameter int W   = 256,
  parameter int W2  = 512,
  parameter int DEG = 163,
  parameter int K1  = 0,
  parameter int K2  = 0,
  parameter int K3  = 7
) (
  input  logic [W2-1:0] raw,
  output logic [W-1:0]  red
);
  import gf2_alu_pkg::*;

  localparam int NF = fold_count(W2, DEG, K3);
  localparam logic [W2-1:0] LOW_MASK = {W2{1'b1}} >> (W2 - DEG);

  logic [W2-1:0] stg [NF+1];
  assign stg[0] = raw;

  for (genvar g = 0; g < NF; g++) begin : g_pass
    logic [W2-1:0] hi;
    logic [W2-1:0] lo;
    assign hi = stg[g] >> DEG;
    assign lo = stg[g] & LOW_MASK;
    assign stg[g+1] = lo ^ hi ^ (hi << K3)
                    ^ ((K2 != 0) ? (hi << K2) : '0)
                    ^ ((K1 != 0) ? (hi << K1) : '0);
  end

  assign red = stg[NF][W-1:0];

  always_comb begin
    AST_FOLD_CLEAN: assert (stg[NF][W2-1:DEG] == '0) else $error("fold residue above degree"); // R7
  end
endmodule

// File: rtl/gf2_reducer.sv
module gf2_reducer #(
  parameter int W = 256
) (
  input  logic [2*W-1:0] raw,
  input  logic [1:0]     fsel,
  output logic [W-1:0]   res
);
  import gf2_alu_pkg::*;

  localparam int W2 = 2 * W;
  logic [W-1:0] r163, r193, r233;

  gf2_fold #(.W(W), .W2(W2), .DEG(163), .K1(3), .K2(6), .K3(7)) u_f163 (
    .raw(raw), .red(r163));
  gf2_fold #(.W(W), .W2(W2), .DEG(193), .K1(0), .K2(0), .K3(15)) u_f193 (
    .raw(raw), .red(r193));
  gf2_fold #(.W(W), .W2(W2), .DEG(233), .K1(0), .K2(0), .K3(74)) u_f233 (
    .raw(raw), .red(r233));

  always_comb begin
    unique case (fsel)
      FS_163:  res = r163;
      FS_193:  res = r193;
      FS_233:  res = r233;
      default: res = raw[W-1:0];
    endcase
  end
endmodule

// File: rtl/gf2_sqr_alu.sv
module gf2_sqr_alu #(
  parameter int W = 256
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [1:0]   in_op,
  input  logic [1:0]   in_fsel,
  input  logic [W-1:0] in_a,
  input  logic [W-1:0] in_b,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] out_result
);
  import gf2_alu_pkg::*;

  logic [2*W-1:0] sq_raw;
  logic [2*W-1:0] raw;
  logic [W-1:0]   res_nxt;
  logic [1:0]     r_op;
  logic [1:0]     r_fsel;

  gf2_interleave #(.W(W)) u_spread (.a(in_a), .sq(sq_raw));

  always_comb begin
    unique case (op_e'(in_op))
      OP_XOR:  raw = {{W{1'b0}}, in_a ^ in_b};
      OP_SQR:  raw = sq_raw;
      OP_SHL:  raw = {{W{1'b0}}, in_a[W-2:0], 1'b0};
      default: raw = '0;
    endcase
  end

  gf2_reducer #(.W(W)) u_reduce (.raw(raw), .fsel(in_fsel), .res(res_nxt));

  assign in_ready = !out_valid || out_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid  <= 1'b0;
      out_result <= '0;
      r_op       <= 2'b00;
      r_fsel     <= FS_RAW;
    end else if (in_ready) begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_result <= res_nxt;
        r_op       <= in_op;
        r_fsel     <= in_fsel;
      end
    end
  end

  function automatic logic [W-1:0] above_deg(logic [1:0] f);
    case (f)
      FS_163:  return {W{1'b1}} << 163;
      FS_193:  return {W{1'b1}} << 193;
      FS_233:  return {W{1'b1}} << 233;
      default: return '0;
    endcase
  endfunction

  function automatic logic [W-1:0] odd_bits();
    logic [W-1:0] m;
    for (int i = 0; i < W; i++) m[i] = i[0];
    return m;
  endfunction

  AST_DEG_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> ((out_result & above_deg(r_fsel)) == '0)); // R7
  AST_ODD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && r_op == OP_SQR && r_fsel == FS_RAW) |-> ((out_result & odd_bits()) == '0)); // R11
  AST_HOLD_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_result))); // R9
  AST_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> out_valid); // R8
endmodule

// File: tb/test_gf2_sqr_alu.sv
module test_gf2_sqr_alu;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         in_valid = 1'b0;
  logic         in_ready;
  logic [1:0]   in_op = 2'b00;
  logic [1:0]   in_fsel = 2'b11;
  logic [255:0] in_a = '0;
  logic [255:0] in_b = '0;
  logic         out_valid;
  logic         out_ready = 1'b1;
  logic [255:0] out_result;

  int tests = 0;
  int fails = 0;
  bit stall_mode = 1'b0;

  bit           m_valid = 1'b0;
  bit           m_acc = 1'b0;
  logic [255:0] m_res = '0;
  logic [1:0]   m_fsel = 2'b11;
  logic [1:0]   m_op = 2'b00;
  string        m_tag = "R1";

  always #4 clk = ~clk;

  gf2_sqr_alu i_gf2_sqr_alu (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_op(in_op), .in_fsel(in_fsel), .in_a(in_a), .in_b(in_b),
    .out_valid(out_valid), .out_ready(out_ready), .out_result(out_result));

  task automatic check(string tag, logic [255:0] got, logic [255:0] exp);
    tests++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, got, exp);
    end
  endtask

  function automatic int deg_of(logic [1:0] f);
    return (f == 2'b00) ? 163 : (f == 2'b01) ? 193 : 233;
  endfunction

  // Bit-serial long division by the selected polynomial.
  function automatic logic [511:0] long_div(logic [511:0] v, logic [1:0] f);
    logic [511:0] p;
    int m;
    m = deg_of(f);
    p = '0;
    p[m] = 1'b1;
    p[0] = 1'b1;
    if (f == 2'b00) begin p[7] = 1'b1; p[6] = 1'b1; p[3] = 1'b1; end
    else if (f == 2'b01) p[15] = 1'b1;
    else p[74] = 1'b1;
    for (int i = 511; i >= m; i--)
      if (v[i]) v = v ^ (p << (i - m));
    return v;
  endfunction

  function automatic logic [255:0] ref_op(logic [1:0] op, logic [1:0] f,
                                          logic [255:0] a, logic [255:0] b);
    logic [511:0] r;
    r = '0;
    case (op)
      2'b00: r[255:0] = a ^ b;
      2'b01: for (int i = 0; i < 256; i++) r[2*i] = a[i];
      2'b10: r[255:0] = {a[254:0], 1'b0};
      default: r = '0;
    endcase
    if (f != 2'b11) r = long_div(r, f);
    return r[255:0];
  endfunction

  function automatic string tag_of(logic [1:0] op, logic [1:0] f);
    if (op == 2'b11) return "R12";
    if (f == 2'b00) return "R4";
    if (f == 2'b01) return "R5";
    if (f == 2'b10) return "R6";
    if (op == 2'b00) return "R1";
    if (op == 2'b01) return "R2";
    return "R3";
  endfunction

  function automatic logic [255:0] rnd256();
    logic [255:0] v;
    for (int i = 0; i < 8; i++) v[32*i +: 32] = $urandom;
    return v;
  endfunction

  // Reference model, sampled 3 ns after the falling edge each cycle.
  always begin
    @(negedge clk);
    #3;
    if (!rst_n) begin
      m_valid = 1'b0;
      m_acc = 1'b0;
    end else begin
      check("R8 out_valid", {255'd0, out_valid}, {255'd0, m_valid});
      if (m_valid) begin
        check(m_tag, out_result, m_res);
        if (m_fsel != 2'b11)
          check("R7 high bits", out_result >> deg_of(m_fsel), '0);
        if (m_op == 2'b01 && m_fsel == 2'b11) begin
          logic [255:0] odd;
          for (int i = 0; i < 256; i++) odd[i] = out_result[i] & i[0];
          check("R11 odd bits", odd, '0);
        end
      end
      check("R9 in_ready", {255'd0, in_ready}, {255'd0, (!m_valid || out_ready)});
      m_acc = in_valid && (!m_valid || out_ready);
      if (m_acc) begin
        m_valid = 1'b1;
        m_res   = ref_op(in_op, in_fsel, in_a, in_b);
        m_tag   = tag_of(in_op, in_fsel);
        m_op    = in_op;
        m_fsel  = in_fsel;
      end else if (out_ready) begin
        m_valid = 1'b0;
      end
    end
  end

  always @(negedge clk) out_ready <= stall_mode ? 1'($urandom % 2) : 1'b1;

  task automatic send(logic [1:0] op, logic [1:0] f, logic [255:0] a, logic [255:0] b);
    @(negedge clk);
    in_valid = 1'b1;
    in_op = op;
    in_fsel = f;
    in_a = a;
    in_b = b;
    do @(posedge clk); while (!m_acc);
  endtask

  task automatic idle(int n);
    @(negedge clk);
    in_valid = 1'b0;
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #1200000;
    fails++;
    $display("FAIL R8 watchdog actual=hung expected=done");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    #3;
    check("R10 out_valid after reset", {255'd0, out_valid}, '0);
    check("R10 in_ready after reset", {255'd0, in_ready}, 256'd1);
    @(negedge clk);
    rst_n = 1'b1;

    // R1: add is XOR; adding twice cancels.
    send(2'b00, 2'b11, {64{4'hA}}, {64{4'h6}});
    send(2'b00, 2'b11, {256{1'b1}}, {256{1'b1}});
    // R2, R11: spread of all ones keeps only even positions.
    send(2'b01, 2'b11, {256{1'b1}}, '0);
    // R3: top bit dropped, bottom filled with zero.
    send(2'b10, 2'b11, {1'b1, 254'd0, 1'b1}, '0);
    // R4..R6: operands sitting on and above each degree.
    send(2'b01, 2'b00, 256'd1 << 162, '0);
    send(2'b10, 2'b00, 256'd1 << 162, '0);
    send(2'b01, 2'b01, {256{1'b1}}, '0);
    send(2'b00, 2'b01, 256'd1 << 200, 256'd1);
    send(2'b01, 2'b10, 256'd1 << 255, '0);
    send(2'b10, 2'b10, 256'd1 << 232, '0);
    // R12: zero op code under every select.
    for (int f = 0; f < 4; f++) send(2'b11, 2'(f), {256{1'b1}}, {256{1'b1}});
    idle(2);

    // R8: back-to-back at full rate, then R9 under random stalls.
    for (int i = 0; i < 120; i++)
      send(2'($urandom % 3), 2'($urandom % 4), rnd256(), rnd256());
    stall_mode = 1'b1;
    for (int i = 0; i < 200; i++)
      send(2'($urandom % 4), 2'($urandom % 4), rnd256(), rnd256());
    idle(1);
    stall_mode = 1'b0;
    idle(6);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule